// File: doc/BRIEF.md
# Gated Clock Frequency Meter

The block measures the frequency of one clock picked from a bank of candidate clocks. Software writes a single control word that carries the window length, the source index, a clock-enable bit, a start bit, and options for repeated measurement and a completion interrupt. It then polls the top bit of that word until it reads zero. The block counts rising edges of the chosen clock, in that clock's own domain, across a window timed by a fixed reference tick. When the window closes, the count passes through a synchronized handshake into the register domain and appears in a result register.

The reference tick is a one-cycle pulse in the register clock domain, nominally at 1 MHz. With a window length field of 9999 the window spans 10000 ticks, so the result is ten times the measured frequency in kHz. In continuous mode the block starts a new window as soon as each result lands. Each new result replaces the previous one, and an interrupt pulse can mark every completed window.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset the control word reads 0, the result register reads 0 and irq is low.
- R2: Control word layout: window length in [15:0], start in bit 16, continuous in bit 17, interrupt enable in bit 18, count-clock enable in bit 19, source index in [26:20], busy in bit 31. Bits [30:27] read 0 and bit 31 cannot be written; every other field reads back as written.
- R3: Writing bit 16 from 0 to 1 while idle makes bit 31 read 1 from the next cycle. A start written while busy is ignored and leaves no pending start.
- R4: The window opens on the first reference tick after the start and closes on the (L+1)-th tick after that, where L is the window length. The result is the number of rising edges of the selected clock inside the window. This holds whenever the window is longer than the round trip of the handshake, including L = 0 for fast clocks.
- R5: Bit 31 falls only after the count has crossed into the register domain. The result register changes only on the cycle in which bit 31 falls.
- R6: With bit 19 clear, the measurement still completes and the result is 0.
- R7: The count saturates at 2^CNT_W-1 and does not wrap.
- R8: The source index is latched when a measurement starts, so a write while busy does not change the source being counted. Index bits above log2(NUM_SRC) are ignored.
- R9: At the end of each window, irq pulses for exactly one cycle, in the same cycle that bit 31 falls, if bit 18 is set. Otherwise irq stays low.
- R10: While bits 16 and 17 are both set, a new window starts in the cycle after each result, using the source index current at that time. Clearing bit 16 lets the window in progress finish and starts no further window.
- R11: Result register bits above CNT_W-1 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| ref_tick | input | 1 | One-cycle reference tick in the clk domain |
| src_clks | input | NUM_SRC | Candidate clocks to be measured |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word read value, busy in bit 31 |
| result_rdata | output | 32 | Edge count of the last completed window |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with NUM_SRC = 8 and CNT_W = 12. Eight clocks, with periods from 2 ns to 100 ns, can then be swept against several window lengths. With the narrow counter, saturation is reached within about a thousand register cycles. Every tick period is a whole multiple of every source period, and the source edges are offset from the register clock edges. The expected count is therefore exactly (L+1)·100/period, and the sweep also covers the index-aliasing, mid-window select changes and continuous-mode sequences.

// File: rtl/clk_freq_meter.sv
`timescale 1ns/1ps
module clk_freq_meter #(
  parameter int NUM_SRC = 128,
  parameter int CNT_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic [NUM_SRC-1:0] src_clks,
  input  logic               ctrl_we,
  input  logic [31:0]        ctrl_wdata,
  output logic [31:0]        ctrl_rdata,
  output logic [31:0]        result_rdata,
  output logic               irq
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_OPEN, S_DRAIN} state_t;
  state_t state;

  logic [15:0] len_q, len_l, tick_cnt;
  logic        start_q, cont_q, ien_q, gclk_q;
  logic [6:0]  sel_q;
  logic [SEL_W-1:0] active_sel;
  logic        active_gate, open_q, elapsed_q, rearm_q, irq_q;
  logic        ack_s1, ack_s2;
  logic [CNT_W-1:0] result_q;

  logic        m_s1, m_s2, m_d;
  logic [CNT_W-1:0] cnt_m;

  logic unused_wbits;
  assign unused_wbits = ^ctrl_wdata[31:27];

  wire busy     = (state != S_IDLE);
  wire start_wr = ctrl_we & ctrl_wdata[16] & ~start_q;
  wire go       = (state == S_IDLE) & (start_wr | rearm_q);

  wire [15:0] nxt_len  = ctrl_we ? ctrl_wdata[15:0] : len_q;
  wire        nxt_gclk = ctrl_we ? ctrl_wdata[19] : gclk_q;
  wire [6:0]  nxt_sel  = ctrl_we ? ctrl_wdata[26:20] : sel_q;

  wire tick_hit = ref_tick && (tick_cnt == len_l);
  wire close_w  = (state == S_OPEN) && (tick_hit || elapsed_q) && ack_s2;

  wire sel_clk = src_clks[active_sel];

  assign ctrl_rdata   = {busy, 4'b0000, sel_q, gclk_q, ien_q, cont_q, start_q, len_q};
  assign result_rdata = {{(32-CNT_W){1'b0}}, result_q};
  assign irq          = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; start_q <= 1'b0; cont_q <= 1'b0; ien_q <= 1'b0;
      gclk_q <= 1'b0; sel_q <= '0;
    end else if (ctrl_we) begin
      len_q   <= ctrl_wdata[15:0];
      start_q <= ctrl_wdata[16];
      cont_q  <= ctrl_wdata[17];
      ien_q   <= ctrl_wdata[18];
      gclk_q  <= ctrl_wdata[19];
      sel_q   <= ctrl_wdata[26:20];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= m_s2;
      ack_s2 <= ack_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; active_sel <= '0; active_gate <= 1'b0; len_l <= '0;
      tick_cnt <= '0; elapsed_q <= 1'b0; open_q <= 1'b0; rearm_q <= 1'b0;
      irq_q <= 1'b0; result_q <= '0;
    end else begin
      irq_q <= 1'b0;
      case (state)
        S_IDLE: if (go) begin
          state       <= S_ARM;
          rearm_q     <= 1'b0;
          active_sel  <= nxt_sel[SEL_W-1:0];
          active_gate <= nxt_gclk;
          len_l       <= nxt_len;
        end
        S_ARM: if (ref_tick) begin
          state     <= S_OPEN;
          open_q    <= 1'b1;
          tick_cnt  <= '0;
          elapsed_q <= 1'b0;
        end
        S_OPEN: begin
          if (close_w) begin
            open_q <= 1'b0;
            state  <= S_DRAIN;
          end else if (tick_hit) begin
            elapsed_q <= 1'b1;
          end else if (ref_tick && !elapsed_q) begin
            tick_cnt <= tick_cnt + 16'd1;
          end
        end
        S_DRAIN: if (!ack_s2) begin
          result_q <= cnt_m;
          irq_q    <= ien_q;
          rearm_q  <= cont_q & start_q;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_d <= 1'b0; cnt_m <= '0;
    end else begin
      m_s1 <= open_q;
      m_s2 <= m_s1;
      m_d  <= m_s2;
      if (m_s2) begin
        if (!m_d)
          cnt_m <= {{(CNT_W-1){1'b0}}, active_gate};
        else if (active_gate && cnt_m != CNT_MAX)
          cnt_m <= cnt_m + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_freq_meter_chk.sv
`timescale 1ns/1ps
module clk_freq_meter_chk #(
  parameter int NUM_SRC = 128,
  parameter int CNT_W   = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_clk,
  input logic             busy,
  input logic             irq,
  input logic [31:0]      result,
  input logic [6:0]       active_sel_ext,
  input logic             open_q,
  input logic             ack_s2,
  input logic             m_s2,
  input logic             m_d,
  input logic             active_gate,
  input logic [CNT_W-1:0] cnt_m
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R9
  irq_at_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $fell(busy));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy));

  // R5
  capture_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!ack_s2 && !open_q));

  // R8
  sel_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(active_sel_ext));

  // R7
  cnt_saturate_chk: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (m_s2 && m_d && cnt_m == CNT_MAX) |=> (cnt_m == CNT_MAX));

  // R6
  gate_off_zero_chk: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (m_s2 && !active_gate) |=> (cnt_m == '0));
endmodule

bind clk_freq_meter clk_freq_meter_chk #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_clk(sel_clk), .busy(ctrl_rdata[31]), .irq(irq),
  .result(result_rdata), .active_sel_ext(7'(active_sel)), .open_q(open_q),
  .ack_s2(ack_s2), .m_s2(m_s2), .m_d(m_d), .active_gate(active_gate), .cnt_m(cnt_m)
);

// File: tb/clk_freq_meter_tb.sv
`timescale 1ns/1ps
module clk_freq_meter_tb_top;
  localparam int NUM_SRC    = 8;
  localparam int CNT_W      = 12;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 10;
  localparam int TICK_NS    = CLK_PERIOD * TICK_DIV;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [NUM_SRC-1:0] src_clks;
  logic [31:0] ctrl_rdata, result_rdata;
  logic irq;
  int checks = 0, errors = 0, irq_cnt = 0, tdiv = 0;
  bit done = 1'b0;

  function automatic int per_ns(int i);
    case (i)
      0: return 5;  1: return 10; 2: return 20; 3: return 25;
      4: return 50; 5: return 100; 6: return 4; default: return 2;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic c;
    initial begin
      c = 1'b0;
      #0.7;
      forever #(per_ns(g) / 2.0) c = ~c;
    end
    assign src_clks[g] = c;
  end

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tdiv     <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    ref_tick <= (tdiv == TICK_DIV - 1);
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  clk_freq_meter #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .src_clks(src_clks),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .result_rdata(result_rdata), .irq(irq)
  );

  function automatic logic [31:0] mk(int len, bit st, bit ct, bit ie, bit gc, int sel);
    return {5'b0, 7'(sel), gc, ie, ct, st, 16'(len)};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (ctrl_rdata[31] && n < 50000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic meas(int sel, int len, bit gc, bit ie);
    wr(mk(len, 0, 0, ie, gc, sel));
    wr(mk(len, 1, 0, ie, gc, sel));
    wait_idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog got 1 exp 0");
    finish_run();
  end

  initial begin
    int i0;
    int lens[3] = '{2, 5, 9};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl", ctrl_rdata, 0);
    chk("R1 result", result_rdata, 0);
    chk("R1 irq", 32'(irq), 0);

    wr(32'hFFFE_FFFF);
    chk("R2 readback", ctrl_rdata, 32'h07FE_FFFF);
    wr(32'h0);
    chk("R2 cleared", ctrl_rdata, 0);

    wr(mk(3, 1, 0, 0, 1, 1));
    chk("R3 busy after start", 32'(ctrl_rdata[31]), 1);
    wait_idle();
    chk("R4 first", result_rdata, 4 * TICK_NS / per_ns(1));

    for (int s = 0; s < NUM_SRC; s++)
      for (int k = 0; k < 3; k++) begin
        meas(s, lens[k], 1, 0);
        chk($sformatf("R4 src%0d len%0d", s, lens[k]), result_rdata,
            (lens[k] + 1) * TICK_NS / per_ns(s));
      end
    meas(6, 0, 1, 0);
    chk("R4 len0 src6", result_rdata, TICK_NS / per_ns(6));
    meas(7, 0, 1, 0);
    chk("R4 len0 src7", result_rdata, TICK_NS / per_ns(7));

    meas(0, 4, 0, 0);
    chk("R6 gate off", result_rdata, 0);

    meas(7, 80, 1, 0);
    chk("R7 below max", result_rdata, 81 * TICK_NS / per_ns(7));
    meas(7, 100, 1, 0);
    chk("R7 saturated", result_rdata, CNT_MAX);
    chk("R11 upper bits", 32'(result_rdata[31:CNT_W]), 0);

    wr(mk(3, 0, 0, 0, 1, 4));
    wr(mk(3, 1, 0, 0, 1, 4));
    wr(mk(3, 1, 0, 0, 1, 1));
    chk("R8 sel readback", 32'(ctrl_rdata[26:20]), 1);
    wait_idle();
    chk("R8 latched sel", result_rdata, 4 * TICK_NS / per_ns(4));
    meas(10, 3, 1, 0);
    chk("R8 alias sel", result_rdata, 4 * TICK_NS / per_ns(2));

    wr(mk(3, 0, 0, 0, 1, 4));
    wr(mk(3, 1, 0, 0, 1, 4));
    wr(mk(3, 0, 0, 0, 1, 4));
    wr(mk(3, 1, 0, 0, 1, 4));
    wait_idle();
    repeat (100) @(negedge clk);
    chk("R3 start ignored when busy", 32'(ctrl_rdata[31]), 0);

    i0 = irq_cnt;
    meas(2, 2, 1, 1);
    repeat (3) @(negedge clk);
    chk("R9 irq once", 32'(irq_cnt - i0), 1);
    i0 = irq_cnt;
    meas(2, 2, 1, 0);
    repeat (3) @(negedge clk);
    chk("R9 irq off", 32'(irq_cnt - i0), 0);

    i0 = irq_cnt;
    wr(mk(4, 0, 1, 1, 1, 1));
    wr(mk(4, 1, 1, 1, 1, 1));
    wr(mk(4, 1, 1, 1, 1, 3));
    wait_idle();
    chk("R10 window1", result_rdata, 5 * TICK_NS / per_ns(1));
    @(negedge clk);
    chk("R10 restart", 32'(ctrl_rdata[31]), 1);
    wait_idle();
    chk("R10 window2", result_rdata, 5 * TICK_NS / per_ns(3));
    @(negedge clk);
    chk("R10 restart2", 32'(ctrl_rdata[31]), 1);
    wr(mk(4, 0, 1, 1, 1, 3));
    wait_idle();
    chk("R10 window3", result_rdata, 5 * TICK_NS / per_ns(3));
    repeat (300) @(negedge clk);
    chk("R10 stopped", 32'(ctrl_rdata[31]), 0);
    chk("R9 irq per window", 32'(irq_cnt - i0), 3);

    finish_run();
  end
endmodule